// File: doc/BRIEF.md
# Stream Ready-Latency Adapter (1 to 0)

This block joins a stream producer that treats ready as a request with one cycle of latency to a consumer that treats ready as an acknowledge with no latency. The producer may present a valid word only in the cycle after it saw the adapter's ready high. The consumer takes a word in any cycle where the adapter's valid and the consumer's ready are both high. Each word carries a data field of parameterised width and two packet flags: a start marker and an end marker.

Both directions are registered. The ready sent upstream comes straight from a flip-flop, and the data, valid and flags sent downstream come from an output holding register. This adds pipelining on the flow-control path as well as on the data path, so the logic feeding the adapter can stay purely combinational. One cycle of upstream ready is always in flight. For that reason a small skid store sits behind the output register and absorbs words that arrive after the consumer has stalled.

A controller tracks how full the storage is. It has four states:
- EMPTY: nothing is held.
- HEAD: only the output register is occupied.
- SKID: the output register is occupied and the skid store is partly filled.
- FULL: every slot is occupied.

The named transitions are:
- load: EMPTY to HEAD.
- stall-in: HEAD to SKID.
- drain-out: HEAD to EMPTY.
- top-up: SKID to FULL, taken when the last free skid slot fills.
- unwind: SKID to HEAD, taken when the final skid word leaves.
- release: FULL to SKID.

A cycle that both accepts and delivers a word keeps the current state.

Top module: `stream_rl_adapter`

## Requirements
- R1: A word leaves the adapter in exactly the cycles in which `out_valid` and `out_ready` are both high. `out_valid` is high exactly when the adapter holds at least one word.
- R2: `in_ready` is a register output. In the first cycle after reset is released it is low, and in the cycle after that it rises, provided the adapter is empty. Every word presented on `in_valid` in the cycle after `in_ready` was high is accepted.
- R3: No accepted word is ever dropped, however long `out_ready` stays low. `in_ready` is high only when the storage can take every word that may still arrive within the one-cycle latency window.
- R4: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sop` and `out_eop` hold their values into the next cycle, and `out_valid` stays high.
- R5: Words leave in the order they were accepted, each exactly once.
- R6: Reset empties the storage. While reset is high, and in the first cycle after it is released, `out_valid` and `in_ready` are low. No word accepted before reset ever appears afterwards.
- R7: A word accepted into an empty adapter is presented on `out_valid` in the next cycle. With `out_ready` held high and the producer sending whenever it is allowed, one word leaves per cycle once the pipeline has filled.
- R8: `out_sop` and `out_eop` always belong to the word on `out_data`. Bit order of a stored word is {sop, eop, data}.
- R9: The adapter holds at most SKID_DEPTH+1 words (3 by default). Starting empty, with `in_ready` high and `out_ready` held low, exactly SKID_DEPTH+1 words are accepted before `in_ready` falls and stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Upstream data word |
| in_sop | input | 1 | Upstream start-of-packet flag |
| in_eop | input | 1 | Upstream end-of-packet flag |
| in_valid | input | 1 | Upstream word present; allowed only one cycle after `in_ready` was high |
| in_ready | output | 1 | Registered request to the producer |
| out_data | output | DATA_W | Downstream data word, registered |
| out_sop | output | 1 | Downstream start-of-packet flag, registered |
| out_eop | output | 1 | Downstream end-of-packet flag, registered |
| out_valid | output | 1 | Downstream word present, registered |
| out_ready | input | 1 | Downstream acknowledge, zero latency |

## Verification
The assertions take for granted that the producer honours the one-cycle request rule: `in_valid` is high only in a cycle that follows a cycle with `in_ready` high. The overflow and FULL-state checks rely on that rule. The bench's producer model keeps within it by latching `in_ready` once per cycle and raising `in_valid` in the following cycle only if that latched value was high, whatever its own sending pattern asks for. Downstream, `out_ready` is left free: it is held high, held low, or toggled by a pseudo-random sequence, because the adapter must cope with any consumer behaviour.

// File: rtl/rla_pkg.sv
`timescale 1ns/1ps
package rla_pkg;

    // Occupancy class of the adapter storage (output register plus skid store).
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,  // no word held
        ST_HEAD  = 2'd1,  // output register only
        ST_SKID  = 2'd2,  // output register plus a partly filled skid store
        ST_FULL  = 2'd3   // every slot occupied
    } rla_state_e;

    // Flag pair carried with every word; the packed word is {sop, eop, data}.
    typedef struct packed {
        logic sop;
        logic eop;
    } rla_flags_t;

endpackage

// File: rtl/rla_skid_store.sv
`timescale 1ns/1ps
module rla_skid_store #(
    parameter int WORD_W = 18,
    parameter int DEPTH  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_word,
    input  logic                 rd_en,
    output logic [WORD_W-1:0]    rd_word,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                 empty,
    output logic                 full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WORD_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [CNT_W-1:0]  count_q;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_ptr_q] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr_q <= ptr_step(wr_ptr_q);
            end
            if (rd_en) begin
                rd_ptr_q <= ptr_step(rd_ptr_q);
            end
            unique case ({wr_en, rd_en})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign rd_word = slots[rd_ptr_q];
    assign count   = count_q;
    assign empty   = (count_q == '0);
    assign full    = (count_q == CNT_W'(DEPTH));

    // R3: the skid store is never written beyond its depth.
    p_skid_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en) |-> !full)
        else $error("skid store written while full");

    // R5: a word is never taken from an empty skid store.
    p_skid_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty)
        else $error("skid store read while empty");

endmodule

// File: rtl/rla_ready_ctrl.sv
`timescale 1ns/1ps
module rla_ready_ctrl #(
    parameter int CAP   = 3,
    parameter int OCC_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occ_next,
    output logic             in_ready
);
    localparam int SUM_W = OCC_W + 2;

    logic             ready_q;
    logic [SUM_W-1:0] worst_case;

    // Words that might occupy storage before this request can be withdrawn:
    // what is held next cycle, one possibly in flight from the current
    // request, and one more if the request is raised again.
    assign worst_case = SUM_W'(occ_next) + SUM_W'(ready_q) + SUM_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= (worst_case <= SUM_W'(CAP));
        end
    end

    assign in_ready = ready_q;

    // R6: the request stays low in the first cycle after reset.
    p_ready_low_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !in_ready)
        else $error("in_ready high right after reset");

endmodule

// File: rtl/stream_rl_adapter.sv
`timescale 1ns/1ps
module stream_rl_adapter #(
    parameter int DATA_W     = 16,
    parameter int SKID_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_valid,
    input  logic              out_ready
);
    import rla_pkg::*;

    localparam int WORD_W = DATA_W + $bits(rla_flags_t);
    localparam int CAP    = SKID_DEPTH + 1;
    localparam int OCC_W  = $clog2(CAP + 1);
    localparam int CNT_W  = $clog2(SKID_DEPTH + 1);

    rla_state_e        state_q, state_d;
    logic [WORD_W-1:0] out_word_q;
    logic              out_valid_q;

    logic [WORD_W-1:0] in_word;
    logic [WORD_W-1:0] skid_word;
    logic [CNT_W-1:0]  skid_cnt;
    logic              skid_empty;
    logic              skid_full;

    logic              push, pop, head_free, direct, skid_wr, skid_rd;
    logic [OCC_W-1:0]  occ, occ_next;

    rla_flags_t        in_flags;

    assign in_flags = '{sop: in_sop, eop: in_eop};
    assign in_word  = {in_flags, in_data};

    // Handshake events.
    assign push      = in_valid;
    assign pop       = out_valid_q & out_ready;
    assign head_free = ~out_valid_q | pop;
    assign direct    = push & skid_empty & head_free;
    assign skid_wr   = push & ~direct;
    assign skid_rd   = head_free & ~skid_empty;

    assign occ      = OCC_W'(out_valid_q) + OCC_W'(skid_cnt);
    assign occ_next = occ + OCC_W'(push) - OCC_W'(pop);

    rla_skid_store #(
        .WORD_W (WORD_W),
        .DEPTH  (SKID_DEPTH)
    ) u_skid (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (skid_wr),
        .wr_word (in_word),
        .rd_en   (skid_rd),
        .rd_word (skid_word),
        .count   (skid_cnt),
        .empty   (skid_empty),
        .full    (skid_full)
    );

    rla_ready_ctrl #(
        .CAP   (CAP),
        .OCC_W (OCC_W)
    ) u_ready (
        .clk      (clk),
        .rst      (rst),
        .occ_next (occ_next),
        .in_ready (in_ready)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: load, stall-in, drain-out, top-up, unwind, release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) state_d = ST_HEAD;                        // load
            end
            ST_HEAD: begin
                if (push && !pop)      state_d = ST_SKID;           // stall-in
                else if (pop && !push) state_d = ST_EMPTY;          // drain-out
            end
            ST_SKID: begin
                if (push && !pop && skid_cnt == CNT_W'(SKID_DEPTH - 1))
                    state_d = ST_FULL;                              // top-up
                else if (pop && !push && skid_cnt == CNT_W'(1))
                    state_d = ST_HEAD;                              // unwind
            end
            ST_FULL: begin
                if (pop && !push) state_d = ST_SKID;                // release
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Output holding register.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_word_q  <= '0;
        end else if (head_free) begin
            if (skid_rd) begin
                out_valid_q <= 1'b1;
                out_word_q  <= skid_word;
            end else if (direct) begin
                out_valid_q <= 1'b1;
                out_word_q  <= in_word;
            end else begin
                out_valid_q <= 1'b0;
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_sop   = out_word_q[WORD_W-1];
    assign out_eop   = out_word_q[WORD_W-2];
    assign out_data  = out_word_q[DATA_W-1:0];

    // R1: output valid agrees with the controller's occupancy class.
    p_valid_tracks_state_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid == (state_q != ST_EMPTY))
        else $error("out_valid disagrees with state");

    // R2: producer contract, a word only follows a raised request.
    p_src_contract_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> $past(in_ready))
        else $error("word arrived without a request");

    // R3: a full adapter never requests, and never receives.
    p_full_blocks_ready_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FULL) |-> !in_ready)
        else $error("request raised while full");

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FULL) |-> !in_valid)
        else $error("word arrived while full");

    // R4: a stalled word is held unchanged.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)))
        else $error("held word changed");

    // R9: FULL is reached only with the skid store full.
    p_full_matches_skid_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FULL) == (skid_full && out_valid))
        else $error("FULL state inconsistent with storage");

endmodule

// File: tb/stream_rl_adapter_tb.sv
`timescale 1ns/1ps
module stream_rl_adapter_tb;
    localparam int DATA_W     = 16;
    localparam int SKID_DEPTH = 2;
    localparam int CAP        = SKID_DEPTH + 1;
    localparam int WORD_W     = DATA_W + 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_sop = 1'b0;
    logic              in_eop = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] out_data;
    logic              out_sop;
    logic              out_eop;
    logic              out_valid;
    logic              out_ready = 1'b0;

    always #10 clk = ~clk;

    stream_rl_adapter #(
        .DATA_W     (DATA_W),
        .SKID_DEPTH (SKID_DEPTH)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    int n_checks = 0;
    int n_bad    = 0;
    bit done     = 1'b0;

    // Producer / consumer modes: 0 off, 1 always, 2 pseudo-random, 3 one word.
    int src_mode = 0;
    int snk_mode = 0;
    bit single_done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic last_rdy = 1'b0;
    logic [DATA_W-1:0] seq = '0;
    logic [WORD_W-1:0] expq[$];
    int sent = 0, recv = 0, cyc = 0, cyc_sent = 0, cyc_recv = 0;
    bit held_v = 1'b0;
    logic [WORD_W-1:0] held_w = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Stream models, active on the falling edge.
    always @(negedge clk) begin
        logic [WORD_W-1:0] w, e;
        bit want;
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rst) begin
            in_valid  = 1'b0;
            last_rdy  = 1'b0;
            out_ready = 1'b0;
            held_v    = 1'b0;
        end else begin
            w = {out_sop, out_eop, out_data};
            if (held_v) begin
                // R4: stalled word unchanged
                check(out_valid && (w == held_w), "R4", "held word", int'(w), int'(held_w));
            end
            want = (src_mode == 1) || (src_mode == 2 && lfsr[0]) ||
                   (src_mode == 3 && !single_done);
            if (want && last_rdy) begin
                in_valid = 1'b1;
                in_data  = seq;
                in_sop   = (seq % 5 == 0);
                in_eop   = (seq % 5 == 4);
                expq.push_back({in_sop, in_eop, in_data});
                sent++;
                cyc_sent = cyc;
                if (src_mode == 3) single_done = 1'b1;
                seq++;
            end else begin
                in_valid = 1'b0;
                in_sop   = 1'b0;
                in_eop   = 1'b0;
            end
            last_rdy  = in_ready;
            out_ready = (snk_mode == 1) || (snk_mode == 2 && lfsr[3]);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R5", "unexpected extra word", int'(w), -1);
                end else begin
                    e = expq.pop_front();
                    // R5 order and R8 flags with their word
                    check(w == e, "R5 R8", "delivered word", int'(w), int'(e));
                end
                recv++;
                cyc_recv = cyc;
                held_v = 1'b0;
            end else begin
                held_v = out_valid;
                held_w = w;
            end
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        src_mode = 0;
        snk_mode = 0;
        wait_cycles(3);
        check(out_valid == 1'b0, "R6", "out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b0, "R6", "in_ready in reset", int'(in_ready), 0);
        expq.delete();
        @(posedge clk);
        #1 rst = 1'b0;
        wait_cycles(1);
        check(in_ready == 1'b0, "R6", "in_ready first cycle after reset", int'(in_ready), 0);
        check(out_valid == 1'b0, "R6", "out_valid after reset", int'(out_valid), 0);
        wait_cycles(1);
        check(in_ready == 1'b1, "R2", "in_ready rises when empty", int'(in_ready), 1);
    endtask

    task automatic t_latency();
        int r0;
        r0 = recv;
        single_done = 1'b0;
        snk_mode = 1;
        src_mode = 3;
        wait_cycles(10);
        src_mode = 0;
        check(recv - r0 == 1, "R1", "single word delivered", recv - r0, 1);
        check(cyc_recv - cyc_sent == 1, "R7", "empty-path latency", cyc_recv - cyc_sent, 1);
    endtask

    task automatic t_full_rate();
        int r0;
        src_mode = 1;
        snk_mode = 1;
        wait_cycles(10);
        r0 = recv;
        wait_cycles(40);
        check(recv - r0 == 40, "R7", "words in 40 streaming cycles", recv - r0, 40);
        src_mode = 0;
        wait_cycles(10);
        check(expq.size() == 0, "R3", "nothing lost after streaming", expq.size(), 0);
    endtask

    task automatic t_capacity();
        int s0, r0;
        wait_cycles(5);
        check(in_ready == 1'b1, "R2", "idle adapter requests", int'(in_ready), 1);
        s0 = sent;
        snk_mode = 0;
        src_mode = 1;
        wait_cycles(12);
        check(sent - s0 == CAP, "R9", "words accepted while stalled", sent - s0, CAP);
        check(in_ready == 1'b0, "R9", "request withdrawn when full", int'(in_ready), 0);
        check(out_valid == 1'b1, "R1", "out_valid while holding", int'(out_valid), 1);
        src_mode = 0;
        r0 = recv;
        snk_mode = 1;
        wait_cycles(10);
        check(recv - r0 == CAP, "R3", "all stalled words delivered", recv - r0, CAP);
        check(expq.size() == 0, "R3", "queue drained", expq.size(), 0);
        check(out_valid == 1'b0, "R1", "out_valid low when empty", int'(out_valid), 0);
    endtask

    task automatic t_random();
        int s0, r0;
        s0 = sent;
        r0 = recv;
        src_mode = 2;
        snk_mode = 2;
        wait_cycles(3000);
        src_mode = 0;
        snk_mode = 1;
        wait_cycles(20);
        check(expq.size() == 0, "R5", "random traffic drained", expq.size(), 0);
        check(sent - s0 == recv - r0, "R5", "sent equals received", recv - r0, sent - s0);
    endtask

    task automatic t_reset_mid();
        int r0;
        snk_mode = 0;
        src_mode = 1;
        wait_cycles(10);
        @(posedge clk);
        #1 rst = 1'b1;
        src_mode = 0;
        wait_cycles(2);
        check(out_valid == 1'b0, "R6", "reset empties storage", int'(out_valid), 0);
        expq.delete();
        snk_mode = 1;
        r0 = recv;
        @(posedge clk);
        #1 rst = 1'b0;
        wait_cycles(10);
        check(recv == r0, "R6", "no stale word after reset", recv - r0, 0);
        check(out_valid == 1'b0, "R6", "still empty after reset", int'(out_valid), 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_full_rate();
        t_capacity();
        t_random();
        t_reset_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog requirement=all actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule